// File: doc/BRIEF.md
# Section BIP-8 Parity Generator

This block produces the section bit-interleaved parity byte for an STS-3c/STM-1 transmit path. It watches the byte stream as it leaves the scrambler and folds every byte of a frame into an 8-bit running parity. Lane n of the result is the exclusive-OR of bit n of every byte in that frame. When the next frame begins, the finished value is moved into a holding register and the running parity restarts with the new frame's first byte.

The framer signals the B1 overhead slot (row 2, column 1 of the transport overhead) of the frame it is assembling. The B1 slot lies before the scrambler, so it falls in the frame that follows the one the parity covers. The block answers one cycle later with the held byte and a one-cycle strobe, and the framer writes that byte into the slot. An invert control, sampled only in the slot cycle, complements the byte. This gives deliberately wrong (odd) parity for error injection. The block needs no frame length. A frame is every valid byte from one start marker up to the next, which is 2430 bytes in normal traffic.

Top module: `bip8_section_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, b1_stb is 0 and b1_byte is 0x00.
- R2: Bit n of the inserted byte, with par_invert at 0, is the even parity of bit n of every valid byte of the most recently completed frame. A frame runs from a byte with scr_sof=1 up to, but not including, the next such byte.
- R3: A cycle with scr_vld at 0 contributes nothing to the parity, whatever is on scr_byte and scr_sof.
- R4: Until a complete frame has been seen after reset, a slot delivers 0x00, or 0xFF if inverted.
- R5: par_invert is sampled only in the cycle where b1_slot is 1. When it is 1 there, the delivered byte is the bitwise complement (odd parity). Its value in other cycles has no effect.
- R6: b1_stb is 1 exactly in the cycle after a cycle with b1_slot=1, and 0 in every other cycle. b1_byte changes only together with b1_stb and otherwise keeps its value.
- R7: When b1_slot and a valid start-of-frame byte occur in the same cycle, the delivered byte covers the frame that this start marker closes.
- R8: Bytes of the frame in progress never affect the delivered byte. A slot late in a frame still reports the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scr_vld | input | 1 | Post-scrambler byte valid |
| scr_sof | input | 1 | Marks the first byte of a frame (with scr_vld) |
| scr_byte | input | 8 | Post-scrambler byte |
| b1_slot | input | 1 | Framer request: B1 slot of the frame being built |
| par_invert | input | 1 | 1 forces odd (wrong) parity for this insertion |
| b1_byte | output | 8 | Parity byte for insertion |
| b1_stb | output | 1 | One-cycle strobe: b1_byte is fresh |

## Verification
Every result is due exactly one clock edge after the b1_slot cycle that requests it. The byte it carries depends on the frames completed up to and including that same edge. A start marker in the slot cycle therefore counts. The bench model updates at each rising edge from the inputs that were present there. Both outputs are compared with the model on every falling edge, so each comparison sees the settled value one register after the stimulus. Stimulus is applied at falling edges, so a slot, a start marker and an invert change can be placed on the same edge on purpose.

// File: rtl/bip8_pkg.sv
package bip8_pkg;
  localparam int unsigned BYTE_W = 8;

  // fold one byte into a running lane parity
  function automatic logic [BYTE_W-1:0] bip_fold(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] din);
    return acc ^ din;
  endfunction

  // apply the error-injection control to a finished parity value
  function automatic logic [BYTE_W-1:0] bip_polarity(input logic [BYTE_W-1:0] par,
                                                     input logic inv);
    return inv ? ~par : par;
  endfunction
endpackage

// File: rtl/bip8_accum.sv
module bip8_accum #(
  parameter int unsigned W = bip8_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic         sof,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] held_o,
  output logic         started_o,
  output logic         close_o,
  output logic [W-1:0] src_o
);
  logic         started_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] held_q;
  logic         boundary;
  logic [W-1:0] finished;

  assign boundary = vld & sof;
  assign finished = started_q ? acc_q : '0;

  // one register per bit lane
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)        acc_q[i] <= 1'b0;
      else if (vld)      acc_q[i] <= sof ? din[i] : (acc_q[i] ^ din[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      held_q    <= '0;
    end else if (boundary) begin
      started_q <= 1'b1;
      held_q    <= finished;
    end
  end

  assign acc_o     = acc_q;
  assign held_o    = held_q;
  assign started_o = started_q;
  assign close_o   = boundary & started_q;
  assign src_o     = boundary ? finished : held_q;
endmodule

// File: rtl/bip8_insert.sv
module bip8_insert #(
  parameter int unsigned W = bip8_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot,
  input  logic         inv,
  input  logic [W-1:0] src,
  output logic [W-1:0] byte_o,
  output logic         stb_o
);
  import bip8_pkg::*;
  logic [W-1:0] byte_q;
  logic         stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= slot;
      if (slot) byte_q <= bip_polarity(src, inv);
    end
  end

  assign byte_o = byte_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/bip8_section_gen.sv
module bip8_section_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_vld,
  input  logic       scr_sof,
  input  logic [7:0] scr_byte,
  input  logic       b1_slot,
  input  logic       par_invert,
  output logic [7:0] b1_byte,
  output logic       b1_stb
);
  localparam int unsigned W = bip8_pkg::BYTE_W;

  logic [W-1:0] acc_w;
  logic [W-1:0] held_w;
  logic         started_w;
  logic         close_w;
  logic [W-1:0] src_w;

  bip8_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .vld(scr_vld), .sof(scr_sof), .din(scr_byte),
    .acc_o(acc_w), .held_o(held_w), .started_o(started_w), .close_o(close_w),
    .src_o(src_w)
  );

  bip8_insert #(.W(W)) u_insert (
    .clk(clk), .rst_n(rst_n), .slot(b1_slot), .inv(par_invert), .src(src_w),
    .byte_o(b1_byte), .stb_o(b1_stb)
  );
endmodule

// File: rtl/bip8_section_chk.sv
module bip8_section_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scr_vld,
  input logic       b1_slot,
  input logic       par_invert,
  input logic [7:0] b1_byte,
  input logic       b1_stb,
  input logic [7:0] acc_w,
  input logic       started_w,
  input logic [7:0] src_w
);
  AST_STB_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    b1_slot |=> b1_stb);  // R6
  AST_STB_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    b1_stb |-> $past(b1_slot));  // R6
  AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !b1_stb |-> $stable(b1_byte));  // R6
  AST_INVERT_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    b1_slot |=> (b1_byte == ($past(src_w) ^ {8{$past(par_invert)}})));  // R5
  AST_NO_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !started_w |-> (src_w == 8'h00));  // R4
  AST_IDLE_NO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_vld |=> $stable(acc_w));  // R3
endmodule

bind bip8_section_gen bip8_section_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scr_vld(scr_vld), .b1_slot(b1_slot),
  .par_invert(par_invert), .b1_byte(b1_byte), .b1_stb(b1_stb),
  .acc_w(acc_w), .started_w(started_w), .src_w(src_w)
);

// File: tb/bip8_section_gen_test.sv
module bip8_section_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scr_vld = 1'b0, scr_sof = 1'b0, b1_slot = 1'b0, par_invert = 1'b0;
  logic [7:0] scr_byte = 8'h00;
  logic [7:0] b1_byte;
  logic       b1_stb;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  byte unsigned cur_frame[$];
  bit           seen_sof = 0;
  logic [7:0]   last_par = 8'h00;
  logic [7:0]   exp_byte = 8'h00;
  logic         exp_stb = 1'b0;

  bip8_section_gen uut (
    .clk(clk), .rst_n(rst_n), .scr_vld(scr_vld), .scr_sof(scr_sof),
    .scr_byte(scr_byte), .b1_slot(b1_slot), .par_invert(par_invert),
    .b1_byte(b1_byte), .b1_stb(b1_stb)
  );

  always #2.5 clk = ~clk;

  // parity of a stored frame: count ones per bit column
  function automatic logic [7:0] column_parity();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      int ones = 0;
      foreach (cur_frame[k]) ones += cur_frame[k][b];
      r[b] = ones % 2;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cur_frame.delete(); seen_sof = 0; last_par = 8'h00;
      exp_byte = 8'h00; exp_stb = 1'b0;
    end else begin
      logic [7:0] completed;
      completed = last_par;
      if (scr_vld && scr_sof) completed = seen_sof ? column_parity() : 8'h00;
      exp_stb = b1_slot;
      if (b1_slot) exp_byte = par_invert ? ~completed : completed;
      if (scr_vld) begin
        if (scr_sof) begin
          last_par = completed; seen_sof = 1; cur_frame.delete();
        end
        cur_frame.push_back(scr_byte);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (b1_stb !== exp_stb) begin
        errors++;
        $display("FAIL %s: b1_stb=%b expected %b at %0t", tag, b1_stb, exp_stb, $time);
      end
      checks++;
      if (b1_byte !== exp_byte) begin
        errors++;
        $display("FAIL %s: b1_byte=%h expected %h at %0t", tag, b1_byte, exp_byte, $time);
      end
    end
  end

  task automatic step(input bit vld, input bit sof, input logic [7:0] d,
                      input bit slot, input bit inv);
    @(negedge clk);
    scr_vld = vld; scr_sof = sof; scr_byte = d; b1_slot = slot; par_invert = inv;
  endtask

  // one frame of n valid bytes; slot at index slot_at (-1 = none), gaps of invalid garbage
  task automatic frame(input int n, input int slot_at, input bit inv, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 5 == 0))
        step(1'b0, $urandom % 2, 8'($urandom), 1'b0, $urandom % 2);
      step(1'b1, i == 0, 8'($urandom), i == slot_at, (i == slot_at) ? inv : 1'($urandom));
    end
  endtask

  initial begin
    tag = "R1";
    repeat (4) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b1; b1_slot = 1'b0; par_invert = 1'b0;
    tag = "R4";
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    frame(40, 10, 1'b1, 1'b0);          // first frame: still nothing completed
    tag = "R2";
    frame(2430, 270, 1'b0, 1'b0);
    tag = "R3";
    frame(2430, 270, 1'b0, 1'b1);
    frame(300, 270, 1'b0, 1'b1);
    tag = "R5";
    frame(2430, 270, 1'b1, 1'b1);
    frame(500, 270, 1'b0, 1'b0);
    tag = "R7";
    frame(200, 0, 1'b0, 1'b0);
    frame(123, 0, 1'b1, 1'b1);
    tag = "R8";
    frame(2430, 2429, 1'b0, 1'b0);
    frame(64, 63, 1'b1, 1'b0);
    tag = "R6";
    frame(50, -1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, i == 0, 8'($urandom), i % 3 == 0, i % 2);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule